// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This unit performs the architectural state change that happens when a processor takes an exception or an interrupt. It receives a one-cycle trap request with a cause, a flag that marks the request as asynchronous, and the faulting address. It also receives the current program counter, the current privilege, the interrupt and exception delegation masks, the status word, and the supervisor and machine trap-vector registers. From these it decides whether supervisor or machine mode handles the trap. It then produces the updated status word, the cause, exception-PC and trap-value registers of the handling mode, the redirect PC and the new privilege.

Everything it produces is held in registers. All of them change together on the clock edge that samples the trap request, and they keep their values between requests. The surrounding core feeds the status output back as the status input of the next trap. Privilege is encoded as 0 for user, 1 for supervisor and 3 for machine. Hypervisor extensions and return-from-trap handling are not part of this block.

Top module: `trap_entry_unit`

## Requirements
- R1: While reset is high, every output is forced to zero at the clock edge, except `next_priv`, which is forced to 3 (machine).
- R2: In a cycle where `trap_valid` is low, every output keeps its value at the next clock edge. When `trap_valid` is high, all outputs update together at that edge and are visible one cycle later.
- R3: The delegation mask is `int_deleg` when `trap_async` is 1 and `exc_deleg` when it is 0. A trap goes to supervisor mode (`next_priv` = 1) only when `cur_priv` is 0 or 1, the final cause is less than XLEN, and the mask bit at the cause's index is set. Every other trap goes to machine mode (`next_priv` = 3), including any trap taken in machine mode.
- R4: On supervisor entry, status bit 5 takes the old bit 1, bit 8 takes bit 0 of `cur_priv`, and bit 1 is cleared. All other status bits pass through from `status_in`. `sepc_out` takes `cur_pc` and `stval_out` takes the trap value. The three machine registers keep their values.
- R5: On machine entry, status bit 7 takes the old bit 3, bits 12:11 take `cur_priv`, and bit 3 is cleared. All other status bits pass through from `status_in`. `mepc_out` takes `cur_pc` and `mtval_out` takes the trap value. The three supervisor registers keep their values.
- R6: The cause register of the handling mode is written with `trap_async` in bit XLEN-1 and the final cause code in its low bits. All bits in between are zero.
- R7: `next_pc` is the handling mode's vector with bits 1:0 cleared. When the trap is asynchronous and vector bits 1:0 equal 01, cause times 4 is added. Synchronous traps, and vectors with any other low-bit value, get no offset.
- R8: The trap value is `trap_addr` for synchronous causes 0, 1, 4, 5, 6, 7, 12, 13 and 15. It is zero for every other synchronous cause and for every asynchronous trap.
- R9: A synchronous cause of 8 is an environment call. Before delegation and recording, it is rewritten to 8 when `cur_priv` is 0, to 9 when it is 1, and to 11 when it is 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | Take a trap in this cycle |
| trap_async | input | 1 | 1 for interrupt, 0 for exception |
| trap_cause | input | CAUSE_W | Raw cause code |
| trap_addr | input | XLEN | Faulting address |
| cur_pc | input | XLEN | PC of the trapping instruction |
| cur_priv | input | 2 | Current privilege |
| int_deleg | input | XLEN | Interrupt delegation mask |
| exc_deleg | input | XLEN | Exception delegation mask |
| status_in | input | XLEN | Current status word |
| svec | input | XLEN | Supervisor trap vector |
| mvec | input | XLEN | Machine trap vector |
| status_out | output | XLEN | Updated status word |
| scause_out | output | XLEN | Supervisor cause register |
| sepc_out | output | XLEN | Supervisor exception PC |
| stval_out | output | XLEN | Supervisor trap value |
| mcause_out | output | XLEN | Machine cause register |
| mepc_out | output | XLEN | Machine exception PC |
| mtval_out | output | XLEN | Machine trap value |
| next_pc | output | XLEN | Redirect PC |
| next_priv | output | 2 | Privilege after the trap |

## Verification
Every result of this unit is due exactly one clock edge after the cycle in which `trap_valid` is sampled high, because the decision path is purely combinational into a single output register stage. The bench drives each request on a falling edge, holds it across one rising edge, and drops it on the next falling edge. It then compares every output at that falling edge, so each comparison sees the state that the single capture edge produced. Hold behaviour is checked by scrambling all inputs over several idle cycles and confirming at falling edges that no output has moved.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    localparam int CAUSE_W = 6;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    // status word bit positions decoded by the rest of the core
    localparam int ST_SIE    = 1;
    localparam int ST_MIE    = 3;
    localparam int ST_SPIE   = 5;
    localparam int ST_MPIE   = 7;
    localparam int ST_SPP    = 8;
    localparam int ST_MPP_LO = 11;
    localparam int ST_MPP_HI = 12;

    localparam logic [CAUSE_W-1:0] CODE_CALL_USER  = CAUSE_W'(8);
    localparam logic [CAUSE_W-1:0] CODE_CALL_SUPER = CAUSE_W'(9);
    localparam logic [CAUSE_W-1:0] CODE_CALL_MACH  = CAUSE_W'(11);

    typedef struct packed {
        logic               to_super;
        logic               async;
        logic               use_addr;
        logic [CAUSE_W-1:0] code;
    } trap_route_t;

    // exceptions whose trap value carries the offending address
    function automatic logic carries_address(input logic [CAUSE_W-1:0] code);
        case (code)
            CAUSE_W'(0), CAUSE_W'(1), CAUSE_W'(4), CAUSE_W'(5),
            CAUSE_W'(6), CAUSE_W'(7), CAUSE_W'(12), CAUSE_W'(13),
            CAUSE_W'(15): carries_address = 1'b1;
            default:      carries_address = 1'b0;
        endcase
    endfunction

    function automatic logic [CAUSE_W-1:0] call_code(input priv_e p,
                                                     input logic [CAUSE_W-1:0] raw);
        case (p)
            PRIV_USER:  call_code = CODE_CALL_USER;
            PRIV_SUPER: call_code = CODE_CALL_SUPER;
            PRIV_MACH:  call_code = CODE_CALL_MACH;
            default:    call_code = raw;
        endcase
    endfunction

endpackage

// File: rtl/trap_decode.sv
module trap_decode
    import trap_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               async_in,
    input  logic [CAUSE_W-1:0] cause_in,
    input  priv_e              priv_in,
    input  logic [XLEN-1:0]    int_mask,
    input  logic [XLEN-1:0]    exc_mask,
    output trap_route_t        route
);
    localparam int IDX_W = $clog2(XLEN);

    logic [CAUSE_W-1:0] code_fix;
    logic [XLEN-1:0]    mask_sel;
    logic               in_range;
    logic               mask_bit;
    logic               low_priv;

    always_comb begin
        if (!async_in && cause_in == CODE_CALL_USER)
            code_fix = call_code(priv_in, cause_in);
        else
            code_fix = cause_in;
    end

    assign mask_sel = async_in ? int_mask : exc_mask;
    assign in_range = (int'(code_fix) < XLEN);
    assign mask_bit = in_range ? mask_sel[code_fix[IDX_W-1:0]] : 1'b0;
    assign low_priv = (priv_in == PRIV_USER) || (priv_in == PRIV_SUPER);

    always_comb begin
        route.to_super = low_priv && mask_bit;
        route.async    = async_in;
        route.use_addr = !async_in && carries_address(code_fix);
        route.code     = code_fix;
    end
endmodule

// File: rtl/trap_target_pc.sv
module trap_target_pc
    import trap_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]    vec_in,
    input  logic               async_in,
    input  logic [CAUSE_W-1:0] code_in,
    output logic [XLEN-1:0]    pc_out
);
    localparam logic [1:0] MODE_SPREAD = 2'b01;

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    assign base   = {vec_in[XLEN-1:2], 2'b00};
    assign offset = (async_in && vec_in[1:0] == MODE_SPREAD)
                  ? (XLEN'(code_in) << 2) : '0;
    assign pc_out = base + offset;
endmodule

// File: rtl/trap_status_next.sv
module trap_status_next
    import trap_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] status_in,
    input  priv_e           priv_in,
    input  logic            to_super,
    output logic [XLEN-1:0] status_out
);
    always_comb begin
        status_out = status_in;
        if (to_super) begin
            status_out[ST_SPIE] = status_in[ST_SIE];
            status_out[ST_SPP]  = priv_in[0];
            status_out[ST_SIE]  = 1'b0;
        end else begin
            status_out[ST_MPIE]             = status_in[ST_MIE];
            status_out[ST_MPP_HI:ST_MPP_LO] = priv_in;
            status_out[ST_MIE]              = 1'b0;
        end
    end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               trap_valid,
    input  logic               trap_async,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [XLEN-1:0]    trap_addr,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [1:0]         cur_priv,
    input  logic [XLEN-1:0]    int_deleg,
    input  logic [XLEN-1:0]    exc_deleg,
    input  logic [XLEN-1:0]    status_in,
    input  logic [XLEN-1:0]    svec,
    input  logic [XLEN-1:0]    mvec,
    output logic [XLEN-1:0]    status_out,
    output logic [XLEN-1:0]    scause_out,
    output logic [XLEN-1:0]    sepc_out,
    output logic [XLEN-1:0]    stval_out,
    output logic [XLEN-1:0]    mcause_out,
    output logic [XLEN-1:0]    mepc_out,
    output logic [XLEN-1:0]    mtval_out,
    output logic [XLEN-1:0]    next_pc,
    output logic [1:0]         next_priv
);
    localparam int PAD_W = XLEN - 1 - CAUSE_W;

    priv_e           priv_cur;
    trap_route_t     route;
    logic [XLEN-1:0] status_nx;
    logic [XLEN-1:0] pc_nx;
    logic [XLEN-1:0] vec_sel;
    logic [XLEN-1:0] cause_word;
    logic [XLEN-1:0] tval_nx;

    assign priv_cur = priv_e'(cur_priv);

    trap_decode #(.XLEN(XLEN)) u_decode (
        .async_in (trap_async),
        .cause_in (trap_cause),
        .priv_in  (priv_cur),
        .int_mask (int_deleg),
        .exc_mask (exc_deleg),
        .route    (route)
    );

    assign vec_sel = route.to_super ? svec : mvec;

    trap_target_pc #(.XLEN(XLEN)) u_target (
        .vec_in   (vec_sel),
        .async_in (route.async),
        .code_in  (route.code),
        .pc_out   (pc_nx)
    );

    trap_status_next #(.XLEN(XLEN)) u_status (
        .status_in  (status_in),
        .priv_in    (priv_cur),
        .to_super   (route.to_super),
        .status_out (status_nx)
    );

    assign cause_word = {route.async, {PAD_W{1'b0}}, route.code};
    assign tval_nx    = route.use_addr ? trap_addr : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_out <= '0;
            scause_out <= '0;
            sepc_out   <= '0;
            stval_out  <= '0;
            mcause_out <= '0;
            mepc_out   <= '0;
            mtval_out  <= '0;
            next_pc    <= '0;
            next_priv  <= PRIV_MACH;
        end else if (trap_valid) begin
            status_out <= status_nx;
            next_pc    <= pc_nx;
            if (route.to_super) begin
                scause_out <= cause_word;
                sepc_out   <= cur_pc;
                stval_out  <= tval_nx;
                next_priv  <= PRIV_SUPER;
            end else begin
                mcause_out <= cause_word;
                mepc_out   <= cur_pc;
                mtval_out  <= tval_nx;
                next_priv  <= PRIV_MACH;
            end
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !trap_valid |=> $stable(next_pc) && $stable(next_priv) && $stable(status_out)
                        && $stable(mepc_out) && $stable(sepc_out)) else $error("idle hold"); // R2

    AST_SUPER_NEEDS_LOW_PRIV: assert property (@(posedge clk) disable iff (rst)
        trap_valid && route.to_super |-> cur_priv != 2'd3 && cur_priv != 2'd2) else $error("deleg priv"); // R3

    AST_SUPER_ENTRY: assert property (@(posedge clk) disable iff (rst)
        trap_valid && route.to_super |=> next_priv == 2'd1 && !status_out[ST_SIE]
                                         && sepc_out == $past(cur_pc)
                                         && $stable(mepc_out)) else $error("s entry"); // R4

    AST_MACH_ENTRY: assert property (@(posedge clk) disable iff (rst)
        trap_valid && !route.to_super |=> next_priv == 2'd3 && !status_out[ST_MIE]
                                          && mepc_out == $past(cur_pc)
                                          && $stable(sepc_out)) else $error("m entry"); // R5

    AST_ASYNC_NO_TVAL: assert property (@(posedge clk) disable iff (rst)
        trap_valid && trap_async |=> (next_priv == 2'd1 ? stval_out : mtval_out) == '0) else $error("async tval"); // R8

    AST_PRIV_LEGAL: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> next_priv == 2'd1 || next_priv == 2'd3) else $error("priv legal"); // R3
endmodule

// File: tb/test_trap_entry_unit.sv
`timescale 1ns/1ps
module test_trap_entry_unit;
    localparam int XLEN = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              trap_valid = 1'b0;
    logic              trap_async = 1'b0;
    logic [5:0]        trap_cause = '0;
    logic [XLEN-1:0]   trap_addr = '0;
    logic [XLEN-1:0]   cur_pc = '0;
    logic [1:0]        cur_priv = 2'd0;
    logic [XLEN-1:0]   int_deleg = '0;
    logic [XLEN-1:0]   exc_deleg = '0;
    logic [XLEN-1:0]   status_in = '0;
    logic [XLEN-1:0]   svec = '0;
    logic [XLEN-1:0]   mvec = '0;
    logic [XLEN-1:0]   status_out, scause_out, sepc_out, stval_out;
    logic [XLEN-1:0]   mcause_out, mepc_out, mtval_out, next_pc;
    logic [1:0]        next_priv;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    trap_entry_unit #(.XLEN(XLEN)) i_trap_entry_unit (
        .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_async(trap_async),
        .trap_cause(trap_cause), .trap_addr(trap_addr), .cur_pc(cur_pc),
        .cur_priv(cur_priv), .int_deleg(int_deleg), .exc_deleg(exc_deleg),
        .status_in(status_in), .svec(svec), .mvec(mvec),
        .status_out(status_out), .scause_out(scause_out), .sepc_out(sepc_out),
        .stval_out(stval_out), .mcause_out(mcause_out), .mepc_out(mepc_out),
        .mtval_out(mtval_out), .next_pc(next_pc), .next_priv(next_priv)
    );

    task automatic check(input string req, input string what,
                         input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic defaults();
        status_in = 32'h0004_000A;
        svec      = 32'h8000_1001;
        mvec      = 32'h8000_2000;
        int_deleg = 32'h0000_0020;
        exc_deleg = 32'h0000_B100;
    endtask

    // one request: driven on a falling edge, captured at the next rising edge
    task automatic fire(input logic async, input logic [5:0] cause, input logic [1:0] priv,
                        input logic [XLEN-1:0] addr, input logic [XLEN-1:0] pc);
        @(negedge clk);
        trap_valid = 1'b1; trap_async = async; trap_cause = cause;
        cur_priv = priv; trap_addr = addr; cur_pc = pc;
        @(negedge clk);
        trap_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "status", status_out, '0);
        check("R1", "next_pc", next_pc, '0);
        check("R1", "next_priv", XLEN'(next_priv), 32'd3);
        check("R1", "mepc", mepc_out, '0);
        check("R1", "scause", scause_out, '0);
    endtask

    task automatic t_page_fault_user();
        fire(1'b0, 6'd13, 2'd0, 32'hDEAD_0000, 32'h0000_4000);
        check("R3", "priv", XLEN'(next_priv), 32'd1);
        check("R4", "status", status_out, 32'h0004_0028);
        check("R4", "sepc", sepc_out, 32'h0000_4000);
        check("R8", "stval", stval_out, 32'hDEAD_0000);
        check("R6", "scause", scause_out, 32'd13);
        check("R7", "pc sync vectored", next_pc, 32'h8000_1000);
        check("R4", "mepc held", mepc_out, '0);
    endtask

    task automatic t_page_fault_mach();
        fire(1'b0, 6'd13, 2'd3, 32'hBEEF_0000, 32'h0000_5000);
        check("R3", "priv", XLEN'(next_priv), 32'd3);
        check("R5", "status", status_out, 32'h0004_1882);
        check("R5", "mepc", mepc_out, 32'h0000_5000);
        check("R5", "mtval", mtval_out, 32'hBEEF_0000);
        check("R6", "mcause", mcause_out, 32'd13);
        check("R7", "pc direct", next_pc, 32'h8000_2000);
        check("R5", "sepc held", sepc_out, 32'h0000_4000);
    endtask

    task automatic t_irq_super();
        fire(1'b1, 6'd5, 2'd1, 32'h1234_5678, 32'h0000_6000);
        check("R3", "priv", XLEN'(next_priv), 32'd1);
        check("R6", "scause", scause_out, 32'h8000_0005);
        check("R8", "stval async", stval_out, '0);
        check("R7", "pc vectored", next_pc, 32'h8000_1014);
        check("R4", "status spp", status_out, 32'h0004_0128);
    endtask

    task automatic t_irq_mach_vectored();
        mvec = 32'h8000_2001;
        fire(1'b1, 6'd7, 2'd3, 32'h0, 32'h0000_7000);
        check("R6", "mcause", mcause_out, 32'h8000_0007);
        check("R7", "pc vectored", next_pc, 32'h8000_201C);
        mvec = 32'h8000_2002;
        fire(1'b1, 6'd7, 2'd1, 32'h0, 32'h0000_7100);
        check("R3", "undelegated irq", XLEN'(next_priv), 32'd3);
        check("R7", "pc mode 2", next_pc, 32'h8000_2000);
        mvec = 32'h8000_2000;
    endtask

    task automatic t_ecalls();
        fire(1'b0, 6'd8, 2'd0, 32'hAAAA_0000, 32'h0000_8000);
        check("R9", "user call", scause_out, 32'd8);
        check("R8", "call tval", stval_out, '0);
        fire(1'b0, 6'd8, 2'd1, 32'h0, 32'h0000_8100);
        check("R9", "super call", mcause_out, 32'd9);
        check("R5", "mpp super", status_out, 32'h0004_0882);
        exc_deleg = 32'hFFFF_FFFF;
        fire(1'b0, 6'd8, 2'd3, 32'h0, 32'h0000_8200);
        check("R9", "mach call", mcause_out, 32'd11);
        check("R3", "mach never delegated", XLEN'(next_priv), 32'd3);
    endtask

    task automatic t_large_cause();
        exc_deleg = 32'hFFFF_FFFF;
        fire(1'b0, 6'd40, 2'd0, 32'h5555_0000, 32'h0000_9000);
        check("R3", "cause >= XLEN", XLEN'(next_priv), 32'd3);
        check("R6", "mcause 40", mcause_out, 32'd40);
        check("R8", "tval 40", mtval_out, '0);
        exc_deleg = 32'h0000_B100;
    endtask

    task automatic t_tval_codes();
        fire(1'b0, 6'd0, 2'd0, 32'h0000_0003, 32'h0000_A000);
        check("R8", "misaligned tval", mtval_out, 32'h0000_0003);
        fire(1'b0, 6'd2, 2'd0, 32'h0000_0777, 32'h0000_A100);
        check("R8", "illegal tval", mtval_out, '0);
    endtask

    task automatic t_hold();
        logic [XLEN-1:0] pc_was, st_was, me_was;
        pc_was = next_pc; st_was = status_out; me_was = mepc_out;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            trap_cause = 6'(i); cur_pc = 32'hFFFF_0000 + i; status_in = ~status_in;
            cur_priv = 2'(i); trap_async = i[0];
        end
        @(negedge clk);
        check("R2", "pc held", next_pc, pc_was);
        check("R2", "status held", status_out, st_was);
        check("R2", "mepc held", mepc_out, me_was);
        defaults();
    endtask

    initial begin
        defaults();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_page_fault_user();
        t_page_fault_mach();
        t_irq_super();
        t_irq_mach_vectored();
        t_ecalls();
        defaults();
        t_large_cause();
        t_tval_codes();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule